// File: doc/BRIEF.md
# JTAG Instruction-Register Length Probe

This block drives a JTAG master pin set through one fixed start-up script, then reports the total instruction-register length of whatever scan chain is attached. It holds TCK low when idle. A start request latches a clock divider value and runs the script. TCK runs at one TCK period per 2×(divider+1) system clocks. TMS and TDI move only while TCK falls.

The script has four parts. It resets the target TAP and walks it into Shift-IR. It then shifts a 32-bit marker word out on TDI, least significant bit first, and follows the marker with a long run of ones. This run of ones puts every device on the chain into bypass. The script ends by stepping the TAP to Update-IR.

While the shift runs, TDO is sampled on each rising TCK edge into a 32-bit window. The block looks for the first point at which the window holds the marker word. The number of bits shifted up to that point, less 32, is the number of TCK cycles by which TDO trails TDI, and this is the chain's IR length. If the marker never appears, the block sets an error flag instead.

Top module: `jtag_irlen_probe`

## Requirements
- R1: The TCK period is 2×(div+1) system clocks, low half first. TCK stays low whenever busy is low. The div value is latched when start is accepted, so later changes to div have no effect on a run in progress.
- R2: TCK cycles 0 to 4 of a run (counted from 0) drive TMS=1 and TDI=0.
- R3: Cycles 5 to 9 drive TDI=0, with TMS equal to 0, 1, 1, 0, 0 in that order.
- R4: Cycles 10 to 41 drive TMS=0. TDI carries the word 0x05253000 over these cycles, bit 0 in cycle 10 and bit 31 in cycle 41.
- R5: Cycles 42 to 281 drive TDI=1. TMS is 0 in all of them except cycle 281, where it is 1.
- R6: Cycle 282 drives TMS=1 and TDI=0 and is the last cycle. TMS and TDI change only on the system clock at which TCK falls, or at the accepted start.
- R7: TDO is sampled only at the rising TCK edges of cycles 10 to 281. Any TDO level during cycles 0 to 9 has no effect on the result.
- R8: When a chain delays TDI to TDO by L cycles (1 ≤ L ≤ 240), ir_len equals L and err is 0. The result is set at the clock on which done pulses and is held until the next accepted start.
- R9: If the 32-bit window never equals the marker word by the end of cycle 281, err is 1 and ir_len is 0.
- R10: After reset, busy, done, err, ir_len, TCK, TMS and TDI are all 0. Busy is high from the clock after start is accepted. Done pulses for exactly one system clock as busy falls, one system clock after the falling TCK edge that ends cycle 282. An accepted start clears err and ir_len.
- R11: Start is ignored while busy is high. Pulsing start during a run leaves the pin waveforms, the busy timing and the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a probe run (accepted only while idle) |
| div | input | DIV_W (8) | Half-period of TCK minus one, in system clocks |
| tdo | input | 1 | Scan chain output, assumed synchronous to clk |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data toward the chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse at the end of a run |
| err | output | 1 | Marker word not seen during the last run |
| ir_len | output | LEN_W (8) | Measured IR length of the last run |

## Verification
A wrong cycle counter or divider state appears on TMS, TDI or TCK at the very next TCK edge, within one system clock of the error. It also moves the done pulse away from the clock on which it is expected. A fault in the TDO window or the bit counter shows only at the end of a run. It appears at the done pulse as a wrong ir_len or a wrong err, so chains of several lengths must each be run to the end. Garbage on TDO before the shift starts shows whether the sampling window is placed correctly.

// File: rtl/irprobe_pkg.sv
// Package: shared constants and the pin script of the IR-length probe.
// Assumes the fixed script: TAP reset, walk to Shift-IR, marker word,
// ones fill, exit to Update-IR. All counts derive from the lengths below.
package irprobe_pkg;

    localparam int RST_CYC   = 5;    // TMS high cycles forcing Test-Logic-Reset
    localparam int IDLE_CYC  = 1;    // one cycle into Run-Test/Idle
    localparam int SEL_CYC   = 2;    // TMS high: select DR then IR path
    localparam int CAP_CYC   = 2;    // TMS low: Capture-IR, then Shift-IR
    localparam int SIG_W     = 32;   // marker word width
    localparam int FILL_CYC  = 240;  // ones fill after the marker
    localparam int UPD_CYC   = 1;    // final step to Update-IR
    localparam int TDO_MASK_CYC = 10; // TDO ignored for this many cycles

    localparam logic [SIG_W-1:0] SIG_WORD = 32'h0525_3000;

    localparam int SHIFT_FIRST  = RST_CYC + IDLE_CYC + SEL_CYC + CAP_CYC;
    localparam int SIG_END      = SHIFT_FIRST + SIG_W;
    localparam int SHIFT_LAST   = SIG_END + FILL_CYC - 1;
    localparam int TOTAL_CYC    = SHIFT_LAST + 1 + UPD_CYC;
    localparam int LAST_CYC     = TOTAL_CYC - 1;
    localparam int SHIFT_BITS   = SIG_W + FILL_CYC;
    localparam int SAMPLE_FIRST = (SHIFT_FIRST > TDO_MASK_CYC) ? SHIFT_FIRST : TDO_MASK_CYC;

    localparam int CYC_W = $clog2(TOTAL_CYC);
    localparam int CNT_W = $clog2(SHIFT_BITS + 1);
    localparam int LEN_W = $clog2(FILL_CYC + 1);

    // TMS level for script cycle c.
    function automatic logic tms_at(input int c);
        if (c < RST_CYC)                       return 1'b1;
        if (c < RST_CYC + IDLE_CYC)            return 1'b0;
        if (c < RST_CYC + IDLE_CYC + SEL_CYC)  return 1'b1;
        if (c < SHIFT_LAST)                    return 1'b0;
        return 1'b1;
    endfunction

    // TDI level for script cycle c.
    function automatic logic tdi_at(input int c);
        logic [SIG_W-1:0] shifted;
        shifted = SIG_WORD >> (c - SHIFT_FIRST);
        if (c < SHIFT_FIRST)  return 1'b0;
        if (c < SIG_END)      return shifted[0];
        if (c <= SHIFT_LAST)  return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/irprobe_tck_gen.sv
// TCK generator: while run is high, toggles TCK every div_val+1 clocks,
// low half first, and flags the clock at which TCK rises or falls.
// Assumes div_val is stable during a run; forces TCK low when run is low.
module irprobe_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tck,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt_q;
    logic             half_end;

    // End of a half period of TCK.
    assign half_end = run && (cnt_q == div_val);
    assign rise_stb = half_end && !tck;
    assign fall_stb = half_end && tck;

    // Half-period counter and TCK toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            tck   <= 1'b0;
        end else if (half_end) begin
            cnt_q <= '0;
            tck   <= !tck;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/irprobe_script.sv
// Script sequencer: steps the TCK cycle index on each falling strobe and
// drives TMS/TDI for the next cycle, so the pins move only as TCK falls.
// Assumes start_acc only while idle; fall_stb comes from irprobe_tck_gen.
module irprobe_script
    import irprobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_acc,
    input  logic             fall_stb,
    output logic             running,
    output logic [CYC_W-1:0] cyc,
    output logic             tms,
    output logic             tdi,
    output logic             last_fall,
    output logic             finish
);

    // Falling edge that closes the final script cycle.
    assign last_fall = running && fall_stb && (int'(cyc) == LAST_CYC);

    // Cycle index, pin levels and end-of-run pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cyc     <= '0;
            tms     <= 1'b0;
            tdi     <= 1'b0;
            finish  <= 1'b0;
        end else begin
            finish <= 1'b0;
            if (start_acc) begin
                running <= 1'b1;
                cyc     <= '0;
                tms     <= tms_at(0);
                tdi     <= tdi_at(0);
            end else if (last_fall) begin
                running <= 1'b0;
                finish  <= 1'b1;
            end else if (running && fall_stb) begin
                cyc <= cyc + 1'b1;
                tms <= tms_at(int'(cyc) + 1);
                tdi <= tdi_at(int'(cyc) + 1);
            end
        end
    end

    // R6: pins move only at a TCK fall or the start of a run.
    a_r6_pins_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tms) || !$stable(tdi)) |-> ($past(fall_stb) || $past(start_acc)));

    // R10: finish follows the end of a run.
    a_r10_finish_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (!running && $past(running)));

endmodule

// File: rtl/irprobe_tdo_match.sv
// TDO matcher: shifts sampled TDO bits into a window (newest at the MSB)
// and records the bit count of the first window equal to the marker.
// Assumes sample pulses once per Shift-IR rising TCK edge; clear restarts.
module irprobe_tdo_match
    import irprobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             tdo,
    output logic             found,
    output logic [LEN_W-1:0] len
);

    logic [SIG_W-1:0] win_q;
    logic [SIG_W-1:0] win_nx;
    logic [CNT_W-1:0] nbits_q;
    logic             hit;

    // Window after taking the current TDO bit.
    assign win_nx = {tdo, win_q[SIG_W-1:1]};
    assign hit    = sample && !found && (win_nx == SIG_WORD) &&
                    (int'(nbits_q) + 1 >= SIG_W);

    // Window, bit counter and first-match capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win_q   <= '0;
            nbits_q <= '0;
            found   <= 1'b0;
            len     <= '0;
        end else if (sample) begin
            win_q   <= win_nx;
            nbits_q <= nbits_q + 1'b1;
            if (hit) begin
                found <= 1'b1;
                len   <= LEN_W'(int'(nbits_q) + 1 - SIG_W);
            end
        end
    end

    // R8: a measured length never exceeds the fill length.
    a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (int'(len) <= FILL_CYC));

    // R8: the first match is kept until cleared.
    a_r8_first_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !clear) |=> (found && $stable(len)));

endmodule

// File: rtl/jtag_irlen_probe.sv
// Top: JTAG IR-length probe. Accepts start while idle, latches the divider,
// runs the pin script and reports the TDI-to-TDO delay of the chain.
// Assumes tdo is already synchronous to clk.
module jtag_irlen_probe
    import irprobe_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic             tdo,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [LEN_W-1:0] ir_len
);

    logic             start_acc;
    logic [DIV_W-1:0] div_q;
    logic             rise_stb;
    logic             fall_stb;
    logic [CYC_W-1:0] cyc;
    logic             last_fall;
    logic             sample;
    logic             found;
    logic [LEN_W-1:0] match_len;

    // A start request counts only while idle.
    assign start_acc = start && !busy;

    // Sample TDO at rising TCK within the Shift-IR window.
    assign sample = rise_stb && busy &&
                    (int'(cyc) >= SAMPLE_FIRST) && (int'(cyc) <= SHIFT_LAST);

    // Latch the divider at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (start_acc) begin
            div_q <= div;
        end
    end

    // Result registers: cleared at start, set at the final TCK fall.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            err    <= 1'b0;
            ir_len <= '0;
        end else if (last_fall) begin
            err    <= !found;
            ir_len <= found ? match_len : '0;
        end
    end

    irprobe_tck_gen #(
        .DIV_W    (DIV_W)
    ) u_tck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div_val  (div_q),
        .tck      (tck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    irprobe_script u_script (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .fall_stb  (fall_stb),
        .running   (busy),
        .cyc       (cyc),
        .tms       (tms),
        .tdi       (tdi),
        .last_fall (last_fall),
        .finish    (done)
    );

    irprobe_tdo_match u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_acc),
        .sample (sample),
        .tdo    (tdo),
        .found  (found),
        .len    (match_len)
    );

    // R1: TCK idles low.
    a_r1_tck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    // R10: done lasts one clock.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an error always reports zero length.
    a_r9_err_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (ir_len == '0));

    // R11: start during a run does not restart or stop it.
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

// File: tb/jtag_irlen_probe_tb.sv
`timescale 1ns/1ps
module jtag_irlen_probe_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] div;
    logic       tdo;
    logic       tck, tms, tdi, busy, done, err;
    logic [7:0] ir_len;

    always #2 clk = ~clk;   // 250 MHz

    jtag_irlen_probe u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .div(div), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
        .err(err), .ir_len(ir_len)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 0;

    // Scan chain model: fixed TDI-to-TDO delay, or an open chain.
    int          chain_len = 4;
    bit          chain_open = 0;
    bit [255:0]  hist = '0;
    int          rise_idx = 0;

    always @(posedge tck) begin
        hist = {hist[254:0], tdi};
        rise_idx++;
    end
    always @(negedge tck) begin
        if (chain_open)         tdo = 1'b0;
        else if (rise_idx < 10) tdo = 1'b1;      // garbage before Shift-IR (R7)
        else                    tdo = hist[chain_len-1];
    end

    // Behavioural reference, advanced on each clock.
    bit    m_busy = 0, m_done = 0, m_err = 0;
    int    m_k = 0, m_d = 0, m_len = 0;
    int    res_len = 0;
    bit    res_err = 0;
    string res_tag = "R8";
    string bsy_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_k = 0; m_len = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (!m_busy && start) begin
                m_busy = 1; m_k = 0; m_d = div; m_len = 0; m_err = 0;
            end else if (m_busy) begin
                m_k++;
                if (m_k == 2 * 283 * (m_d + 1)) begin
                    m_busy = 0; m_done = 1; m_len = res_len; m_err = res_err;
                end
            end
        end
    end

    function automatic bit ref_tms(int c);
        if (c < 5) return 1;
        if (c == 5) return 0;
        if (c == 6 || c == 7) return 1;
        if (c < 281) return 0;
        return 1;
    endfunction

    function automatic bit ref_tdi(int c);
        bit [31:0] s;
        s = 32'h0525_3000;
        if (c >= 10 && c < 42) return s[c-10];
        if (c >= 42 && c <= 281) return 1;
        return 0;
    endfunction

    function automatic string pin_tag(int c);
        if (c < 5)   return "R2";
        if (c < 10)  return "R3";
        if (c < 42)  return "R4";
        if (c < 282) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge.
    bit cmp_en = 0;
    always @(negedge clk) begin
        if (cmp_en) begin
            int c;
            int etck;
            c = m_k / (2 * (m_d + 1));
            etck = (m_busy && ((m_k / (m_d + 1)) % 2 == 1)) ? 1 : 0;
            chk("R1", "tck", int'(tck), etck);
            chk(bsy_tag, "busy", int'(busy), int'(m_busy));
            chk("R10", "done", int'(done), int'(m_done));
            chk(res_tag, "ir_len", int'(ir_len), m_len);
            chk(res_tag, "err", int'(err), int'(m_err));
            if (m_busy) begin
                chk(pin_tag(c), "tms", int'(tms), int'(ref_tms(c)));
                chk(pin_tag(c), "tdi", int'(tdi), int'(ref_tdi(c)));
            end else if (!rst_n) begin
                chk("R10", "tms reset", int'(tms), 0);
                chk("R10", "tdi reset", int'(tdi), 0);
            end
        end
    end

    task automatic finish_report();
        if (!summary_done) begin
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One probe run; optionally pokes start and div mid-run (R11, R1).
    task automatic run_probe(int d, int len, bit open, string tag, bit poke);
        @(negedge clk);
        chain_len  = len;
        chain_open = open;
        hist       = '0;
        rise_idx   = 0;
        res_err    = open || (len > 240);
        res_len    = res_err ? 0 : len;
        res_tag    = tag;
        div        = 8'(d);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            bsy_tag = "R11";
            repeat (300) @(negedge clk);
            div   = 8'(d + 2);          // R1: must not affect this run
            start = 1'b1;               // R11: ignored while busy
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (5) @(negedge clk);
        bsy_tag = "R10";
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_report();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        div   = 8'd0;
        tdo   = 1'b0;
        @(posedge clk);
        cmp_en = 1;                     // R10 reset state compared from here
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_probe(0, 4,   0, "R8", 0);  // single 4-bit IR
        run_probe(1, 1,   0, "R8", 0);
        run_probe(3, 9,   0, "R7", 0);  // garbage TDO early must not matter
        run_probe(0, 240, 0, "R8", 0);  // longest measurable chain
        run_probe(0, 241, 0, "R9", 0);  // too long: no match
        run_probe(1, 4,   1, "R9", 0);  // open chain
        run_probe(1, 13,  0, "R11", 1); // start and div poked mid-run
        run_probe(0, 2,   0, "R8", 0);  // result cleared and re-measured
        finish_report();
    end

endmodule